// File: doc/BRIEF.md
# Dual Circular-Buffer Address Generator

This block contains two address generators that work side by side. Each can supply one memory address per clock for indirect data access. Each generator holds a small bank of index registers (current pointers), step registers (signed increments) and length registers (circular buffer sizes). On an access request, the generator presents the chosen index register as the next address. In the same clock it advances that index by the chosen step. When the paired length is non-zero, the advance wraps so that the pointer stays inside its circular buffer.

Each generator also has a mode bit that presents addresses with all bits in reverse order, for FFT-style access. The reversal changes only the emitted address and never the stored pointer. Software configures both generators through a single synchronous register port. The port selects the generator, the register kind and the register number.

Top module: `dual_dag`

## Requirements
- R1: While `rst` is high and after it falls, every index, step, length and base register is zero, the mode bits are zero, both address outputs are zero and both valid outputs are low.
- R2: A write with `reg_we` high stores `reg_wdata` into the register chosen by `reg_gen` (0 = generator A, 1 = generator B), `reg_kind` and `reg_idx`. The `reg_kind` codes are 0 = index, 1 = step, 2 = length and 3 = mode; for code 3 only bit 0 is kept and `reg_idx` is ignored. `reg_rdata` shows the selected register one clock after the select is applied, and reads of the mode register return the mode in bit 0 and zero above it.
- R3: An access request (`req_x` high) makes `vld_x` high in the next cycle, and `addr_x` then holds the pre-update content of the index register chosen by `isel_x`.
- R4: When the paired length is zero, the chosen index register becomes index + step after the access. The step is treated as signed two's complement and the sum is taken modulo 2^AW, so it wraps in both directions.
- R5: When the length L is non-zero, call base the value of that index register at the time L was written. If index + step reaches base + L or more, L is subtracted from it; if it falls below base, L is added to it. This holds for step magnitudes below L.
- R6: With the generator's mode bit set, `addr_x` shows the index with bit order reversed (bit 0 goes to bit AW-1), while the stored index advances exactly as in R4/R5.
- R7: The two generators are independent. Both may be accessed in the same cycle, and neither one's registers or outputs depend on the other's requests or configuration.
- R8: If a register write targets the same index register that an access uses in the same cycle, the written value is stored. The address emitted for that access is still the old index.
- R9: Without a request, `vld_x` is low in the next cycle, `addr_x` keeps its value and no index register of that generator changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_gen | input | 1 | Generator select for register port (0 = A, 1 = B) |
| reg_kind | input | 2 | Register kind: 0 index, 1 step, 2 length, 3 mode |
| reg_idx | input | SW | Register number within the kind |
| reg_wdata | input | AW | Write data |
| reg_rdata | output | AW | Registered read data |
| req_a | input | 1 | Access request, generator A |
| isel_a | input | SW | Index register select, generator A |
| msel_a | input | SW | Step register select, generator A |
| addr_a | output | AW | Registered address, generator A |
| vld_a | output | 1 | Address valid, generator A |
| req_b | input | 1 | Access request, generator B |
| isel_b | input | SW | Index register select, generator B |
| msel_b | input | SW | Step register select, generator B |
| addr_b | output | AW | Registered address, generator B |
| vld_b | output | 1 | Address valid, generator B |

## Verification
Two functions meet in one cycle here: an access that post-modifies an index register, and a register-port write to that same register. The bench provokes this by issuing an access to index register 1 of generator A while writing a new value to it. It then expects the old pointer on `addr_a`, and the written value when the register is read back. The parameter sweeps also run both generators in every access cycle with opposite step signs. Each generator's address stream is compared against its own arithmetic model, which shows that simultaneous use causes no interference.

// File: rtl/dag_pkg.sv
package dag_pkg;
    localparam int DAG_AW   = 14;
    localparam int DAG_NSET = 4;

    typedef enum logic [1:0] {
        KIND_IDX  = 2'd0,
        KIND_STEP = 2'd1,
        KIND_LEN  = 2'd2,
        KIND_MODE = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/dag_wrap.sv
module dag_wrap #(
    parameter int AW = dag_pkg::DAG_AW
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] len,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] nxt
);
    localparam int XW = AW + 2;

    logic signed [XW-1:0] sum, lim, lo, lx;

    always_comb begin
        sum = $signed({2'b00, cur}) + $signed({{2{step[AW-1]}}, step});
        lo  = $signed({2'b00, base});
        lx  = $signed({2'b00, len});
        lim = lo + lx;
        if (len == '0)
            nxt = sum[AW-1:0];
        else if (sum >= lim)
            nxt = AW'(sum - lx);
        else if (sum < lo)
            nxt = AW'(sum + lx);
        else
            nxt = sum[AW-1:0];
    end
endmodule

// File: rtl/dag_unit.sv
module dag_unit #(
    parameter int AW   = dag_pkg::DAG_AW,
    parameter int NSET = dag_pkg::DAG_NSET,
    localparam int SW  = $clog2(NSET)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  dag_pkg::reg_kind_e  kind,
    input  logic [SW-1:0]       ridx,
    input  logic [AW-1:0]       wdata,
    output logic [AW-1:0]       rdata,
    input  logic                req,
    input  logic [SW-1:0]       isel,
    input  logic [SW-1:0]       msel,
    output logic [AW-1:0]       addr,
    output logic                vld
);
    import dag_pkg::*;

    logic [AW-1:0] ireg [NSET];
    logic [AW-1:0] mreg [NSET];
    logic [AW-1:0] lreg [NSET];
    logic [AW-1:0] breg [NSET];
    logic          mode;

    logic [AW-1:0] cur, nxt, rev;

    assign cur = ireg[isel];

    for (genvar b = 0; b < AW; b++) begin : g_rev
        assign rev[b] = cur[AW-1-b];
    end

    dag_wrap #(.AW(AW)) u_wrap (
        .cur  (cur),
        .step (mreg[msel]),
        .len  (lreg[isel]),
        .base (breg[isel]),
        .nxt  (nxt)
    );

    always_comb begin
        unique case (kind)
            KIND_IDX:  rdata = ireg[ridx];
            KIND_STEP: rdata = mreg[ridx];
            KIND_LEN:  rdata = lreg[ridx];
            default:   rdata = {{(AW-1){1'b0}}, mode};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NSET; k++) begin
                ireg[k] <= '0;
                mreg[k] <= '0;
                lreg[k] <= '0;
                breg[k] <= '0;
            end
            mode <= 1'b0;
            addr <= '0;
            vld  <= 1'b0;
        end else begin
            vld <= req;
            if (req) begin
                addr       <= mode ? rev : cur;
                ireg[isel] <= nxt;
            end
            // register port is applied last so that it wins a collision
            if (we) begin
                unique case (kind)
                    KIND_IDX:  ireg[ridx] <= wdata;
                    KIND_STEP: mreg[ridx] <= wdata;
                    KIND_LEN: begin
                        lreg[ridx] <= wdata;
                        breg[ridx] <= ireg[ridx];
                    end
                    default:   mode <= wdata[0];
                endcase
            end
        end
    end
endmodule

// File: rtl/dual_dag.sv
module dual_dag #(
    parameter int AW   = dag_pkg::DAG_AW,
    parameter int NSET = dag_pkg::DAG_NSET,
    localparam int SW  = $clog2(NSET)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic          reg_gen,
    input  logic [1:0]    reg_kind,
    input  logic [SW-1:0] reg_idx,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic          req_a,
    input  logic [SW-1:0] isel_a,
    input  logic [SW-1:0] msel_a,
    output logic [AW-1:0] addr_a,
    output logic          vld_a,
    input  logic          req_b,
    input  logic [SW-1:0] isel_b,
    input  logic [SW-1:0] msel_b,
    output logic [AW-1:0] addr_b,
    output logic          vld_b
);
    import dag_pkg::*;

    localparam int NGEN = 2;

    logic          g_req  [NGEN];
    logic [SW-1:0] g_isel [NGEN];
    logic [SW-1:0] g_msel [NGEN];
    logic [AW-1:0] g_addr [NGEN];
    logic          g_vld  [NGEN];
    logic [AW-1:0] g_rd   [NGEN];

    reg_kind_e kind;
    assign kind = reg_kind_e'(reg_kind);

    assign g_req[0]  = req_a;
    assign g_isel[0] = isel_a;
    assign g_msel[0] = msel_a;
    assign g_req[1]  = req_b;
    assign g_isel[1] = isel_b;
    assign g_msel[1] = msel_b;

    for (genvar g = 0; g < NGEN; g++) begin : g_gen
        dag_unit #(.AW(AW), .NSET(NSET)) u_unit (
            .clk   (clk),
            .rst   (rst),
            .we    (reg_we && (reg_gen == 1'(g))),
            .kind  (kind),
            .ridx  (reg_idx),
            .wdata (reg_wdata),
            .rdata (g_rd[g]),
            .req   (g_req[g]),
            .isel  (g_isel[g]),
            .msel  (g_msel[g]),
            .addr  (g_addr[g]),
            .vld   (g_vld[g])
        );
    end

    assign addr_a = g_addr[0];
    assign vld_a  = g_vld[0];
    assign addr_b = g_addr[1];
    assign vld_b  = g_vld[1];

    always_ff @(posedge clk) begin
        if (rst) reg_rdata <= '0;
        else     reg_rdata <= g_rd[reg_gen];
    end
endmodule

// File: rtl/dag_chk.sv
module dag_chk #(
    parameter int AW = dag_pkg::DAG_AW
) (
    input logic          clk,
    input logic          rst,
    input logic          req_a,
    input logic          vld_a,
    input logic [AW-1:0] addr_a,
    input logic          req_b,
    input logic          vld_b,
    input logic [AW-1:0] addr_b
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!vld_a && !vld_b && addr_a == '0 && addr_b == '0)); // R1
    AST_REQ_A_VALID: assert property (@(posedge clk) disable iff (rst)
        req_a |=> vld_a); // R3
    AST_REQ_B_VALID: assert property (@(posedge clk) disable iff (rst)
        req_b |=> vld_b); // R3
    AST_BOTH_SERVED: assert property (@(posedge clk) disable iff (rst)
        (req_a && req_b) |=> (vld_a && vld_b)); // R7
    AST_IDLE_A_HOLD: assert property (@(posedge clk) disable iff (rst)
        !req_a |=> (!vld_a && $stable(addr_a))); // R9
    AST_IDLE_B_HOLD: assert property (@(posedge clk) disable iff (rst)
        !req_b |=> (!vld_b && $stable(addr_b))); // R9
endmodule

bind dual_dag dag_chk #(.AW(AW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .req_a  (req_a),
    .vld_a  (vld_a),
    .addr_a (addr_a),
    .req_b  (req_b),
    .vld_b  (vld_b),
    .addr_b (addr_b)
);

// File: tb/tb_dual_dag.sv
module tb_dual_dag;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 14;
    localparam int SW  = 2;
    localparam int MODV = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          reg_we, reg_gen;
    logic [1:0]    reg_kind;
    logic [SW-1:0] reg_idx;
    logic [AW-1:0] reg_wdata, reg_rdata;
    logic          req_a, req_b, vld_a, vld_b;
    logic [SW-1:0] isel_a, msel_a, isel_b, msel_b;
    logic [AW-1:0] addr_a, addr_b;

    int n_chk = 0;
    int n_bad = 0;

    // bench model
    int m_i [2][4];
    int m_m [2][4];
    int m_l [2][4];
    int m_b [2][4];
    int m_mode [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_dag dut (.*);

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int wrapm(int v);
        return ((v % MODV) + MODV) % MODV;
    endfunction

    function automatic int sgn(int v);
        return (v >= MODV/2) ? v - MODV : v;
    endfunction

    function automatic int step_next(int g, int i, int m);
        int s = m_i[g][i] + sgn(m_m[g][m]);
        if (m_l[g][i] == 0) return wrapm(s);
        if (s >= m_b[g][i] + m_l[g][i]) return s - m_l[g][i];
        if (s < m_b[g][i]) return s + m_l[g][i];
        return s;
    endfunction

    function automatic int brev(int v);
        int r = 0;
        for (int k = 0; k < AW; k++) if (v[k]) r |= 1 << (AW-1-k);
        return r;
    endfunction

    task automatic wr(int g, int kind, int idx, int data);
        @(negedge clk);
        reg_we = 1'b1; reg_gen = 1'(g); reg_kind = 2'(kind);
        reg_idx = SW'(idx); reg_wdata = AW'(data);
        @(posedge clk);
        case (kind)
            0: m_i[g][idx] = wrapm(data);
            1: m_m[g][idx] = wrapm(data);
            2: begin m_l[g][idx] = wrapm(data); m_b[g][idx] = m_i[g][idx]; end
            default: m_mode[g] = data & 1;
        endcase
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(string req, int g, int kind, int idx, int exp);
        @(negedge clk);
        reg_we = 1'b0; reg_gen = 1'(g); reg_kind = 2'(kind); reg_idx = SW'(idx);
        @(negedge clk);
        chk(req, int'(reg_rdata), exp);
    endtask

    // one access cycle, optional on each generator; checks outputs after the edge
    task automatic acc(string req, bit ra, int ia, int ma, bit rb, int ib, int mb);
        int ea, eb;
        @(negedge clk);
        req_a = ra; isel_a = SW'(ia); msel_a = SW'(ma);
        req_b = rb; isel_b = SW'(ib); msel_b = SW'(mb);
        ea = ra ? (m_mode[0] ? brev(m_i[0][ia]) : m_i[0][ia]) : int'(addr_a);
        eb = rb ? (m_mode[1] ? brev(m_i[1][ib]) : m_i[1][ib]) : int'(addr_b);
        @(posedge clk);
        if (ra) m_i[0][ia] = step_next(0, ia, ma);
        if (rb) m_i[1][ib] = step_next(1, ib, mb);
        @(negedge clk);
        req_a = 1'b0; req_b = 1'b0;
        chk({req, " vld_a"}, int'(vld_a), int'(ra));
        chk({req, " vld_b"}, int'(vld_b), int'(rb));
        chk({req, " addr_a"}, int'(addr_a), ea);
        chk({req, " addr_b"}, int'(addr_b), eb);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int lens [5] = '{0, 1, 3, 4, 7};
        int steps [5] = '{-3, -1, 0, 2, 5};
        reg_we = 0; reg_gen = 0; reg_kind = 0; reg_idx = 0; reg_wdata = 0;
        req_a = 0; req_b = 0; isel_a = 0; msel_a = 0; isel_b = 0; msel_b = 0;
        for (int g = 0; g < 2; g++) begin
            m_mode[g] = 0;
            for (int k = 0; k < 4; k++) begin
                m_i[g][k] = 0; m_m[g][k] = 0; m_l[g][k] = 0; m_b[g][k] = 0;
            end
        end
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 vld_a reset", int'(vld_a), 0);
        chk("R1 addr_b reset", int'(addr_b), 0);
        rst = 1'b0;
        for (int g = 0; g < 2; g++)
            for (int k = 0; k < 4; k++) begin
                rd("R1 index zero", g, 0, k, 0);
                rd("R1 length zero", g, 2, k, 0);
            end
        rd("R1 mode zero", 1, 3, 0, 0);

        // R2 register port round trip over every kind and slot
        for (int g = 0; g < 2; g++)
            for (int kd = 0; kd < 3; kd++)
                for (int k = 0; k < 4; k++) begin
                    wr(g, kd, k, 37 * (k + 1) + 1000 * kd + 7 * g);
                    rd("R2 readback", g, kd, k, 37 * (k + 1) + 1000 * kd + 7 * g);
                end
        wr(0, 3, 2, 16'h3);
        rd("R2 mode bit only", 0, 3, 0, 1);
        wr(0, 3, 0, 0);
        rd("R2 mode cleared", 0, 3, 0, 0);

        // R3 R4 R5 R7: sweep of length and step, both generators running together
        foreach (lens[li])
            foreach (steps[si]) begin
                int L = lens[li];
                int S = steps[si];
                int ab = (S < 0) ? -S : S;
                if (L != 0 && ab >= L) continue;
                wr(0, 0, 2, 100);  wr(0, 2, 2, L);  wr(0, 1, 3, wrapm(S));
                wr(1, 0, 1, 300);  wr(1, 2, 1, L);  wr(1, 1, 0, wrapm(-S));
                for (int n = 0; n < 9; n++)
                    acc(L == 0 ? "R4 R7 linear" : "R5 R7 circular", 1, 2, 3, 1, 1, 0);
                rd("R5 stored index A", 0, 0, 2, m_i[0][2]);
                rd("R5 stored index B", 1, 0, 1, m_i[1][1]);
            end

        // R4 modulo wrap at both ends of the address space
        wr(0, 0, 0, MODV - 2); wr(0, 2, 0, 0); wr(0, 1, 0, 1);
        acc("R4 top", 1, 0, 0, 0, 0, 0);
        acc("R4 top", 1, 0, 0, 0, 0, 0);
        rd("R4 wrapped to zero", 0, 0, 0, 0);
        wr(0, 1, 1, wrapm(-1));
        acc("R4 bottom", 1, 0, 1, 0, 0, 0);
        rd("R4 wrapped to top", 0, 0, 0, MODV - 1);

        // R6 bit reversal on generator B only
        wr(1, 3, 0, 1); wr(1, 0, 3, 1); wr(1, 2, 3, 0); wr(1, 1, 2, 3);
        for (int n = 0; n < 6; n++) acc("R6 reversed", 1, 0, 0, 1, 3, 2);
        rd("R6 stored index not reversed", 1, 0, 3, 19);
        wr(1, 3, 0, 0);
        acc("R6 mode off", 0, 0, 0, 1, 3, 2);

        // R8 write and access on the same index register
        wr(0, 0, 1, 40); wr(0, 2, 1, 0); wr(0, 1, 2, 5);
        @(negedge clk);
        req_a = 1; isel_a = 1; msel_a = 2;
        reg_we = 1; reg_gen = 0; reg_kind = 0; reg_idx = 1; reg_wdata = 500;
        @(negedge clk);
        req_a = 0; reg_we = 0;
        chk("R8 address is old index", int'(addr_a), 40);
        m_i[0][1] = 500;
        rd("R8 write wins", 0, 0, 1, 500);

        // R9 idle cycles keep state and output
        acc("R9 idle", 0, 0, 0, 0, 0, 0);
        acc("R9 idle", 0, 1, 2, 0, 3, 2);
        rd("R9 index unchanged", 0, 0, 1, 500);
        rd("R9 index unchanged B", 1, 0, 3, m_i[1][3]);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule